// File: doc/BRIEF.md
# PHY Media Selection Sequencer

This block picks the operating mode of an Ethernet MAC after reset by talking to the attached transceiver through a request/response management port. A strap input marks the 10-Mb-only device variant. For that variant the block forces the transceiver's control register to zero and does no link polling. For every other variant it polls the transceiver status until link and auto-negotiation are both reported, or until a timeout expires. When the link comes up it reads the specific status register to decide duplex. When the timeout expires it selects the alternate home-network transceiver instead.

The 32-bit mode word is presented with a single-cycle valid strobe, and it always carries the store-and-forward bit. On the fallback path the block then identifies the home-network transceiver. It applies one of two revision-dependent register patches, and finishes with a done pulse. The block starts on its own when reset is released. It runs once per reset and leaves the serial management framing to the master behind the port.

Top module: `phy_mode_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `mreq_valid`, `mode_valid` and `seq_done` are low and `mode_word` reads 0x0020_0000. The sequence then starts with no other stimulus.
- R2: Every mode word presented with `mode_valid` has bit 21 (store-and-forward) set.
- R3: With `strap_10m` high, the only management access is one write of 0x0000 to register 0. Register 1 is never read, and the mode word is 0x0020_0000.
- R4: At most one management access is outstanding. Each request is a one-cycle `mreq_valid` pulse, and the next request follows only after `mresp_done` for the previous one. With the strap low, register 1 is read again and again until a read shows bits 5 and 2 both set (mask 0x0024).
- R5: When a register 1 read shows both link bits, register 17 is read. Mode bit 9 (full duplex) is set if bit 15 or bit 13 of that value is 1, and clear otherwise.
- R6: If a register 1 read without both link bits completes after `TIMEOUT_CYC` clocks of polling, mode bit 18 (alternate transceiver) is set. The mode word then appears no sooner than `TIMEOUT_CYC` cycles after the first poll request.
- R7: `mode_valid` pulses exactly once per reset. With the strap low, no management write is issued before that pulse.
- R8: On the fallback path register 3 is read. If (value AND 0xFFF0) differs from 0xB900, no write follows.
- R9: If register 3 matches and register 31 reads 0x4404, register 16 is written with 0x0005 when register 3 was 0xB901 and with 0x1005 otherwise. Register 24 is then read and register 25 written with ((value + 3) AND 0xFF) OR 0xF000.
- R10: If register 3 matches and register 31 reads anything else, register 16 is written with 0x0005. Register 25 is then read and written back with (value AND 0xFF00) + 2.
- R11: `seq_done` pulses exactly once, one cycle after `mode_valid` or after the last response of the chosen path, whichever is later. No request follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_10m | input | 1 | High selects the 10-Mb-only device variant |
| mreq_valid | output | 1 | One-cycle management request pulse |
| mreq_write | output | 1 | 1 = write, 0 = read; held until the response |
| mreq_reg | output | 5 | Transceiver register number; held until the response |
| mreq_wdata | output | 16 | Write data; held until the response |
| mresp_done | input | 1 | One-cycle completion pulse from the management master |
| mresp_rdata | input | 16 | Read data, valid with `mresp_done` |
| mode_word | output | 32 | MAC operating-mode word |
| mode_valid | output | 1 | One-cycle strobe marking `mode_word` final |
| seq_done | output | 1 | One-cycle pulse when all accesses are finished |

## Verification
A request pulse comes one cycle after the sequencer enters an access step. Every result that depends on a response is due one cycle after the edge on which `mresp_done` is sampled. `mode_valid` comes one cycle after the deciding response, and `seq_done` follows `mode_valid` or the last response by one cycle. The bench model answers each request after a random latency of zero to two cycles. It samples every output on the falling edge, so each pulse is seen in the cycle it is due. The timeout bound is checked by counting cycles from the first poll request to the mode strobe. Write order and write data are compared against a list the bench computes from the register contents it preset.

// File: rtl/phy_mode_pkg.sv
package phy_mode_pkg;
  localparam int REG_AW = 5;
  localparam int DATA_W = 16;
  localparam int MODE_W = 32;

  // transceiver register numbers the sequence depends on
  localparam logic [REG_AW-1:0] RG_CTRL   = 5'd0;
  localparam logic [REG_AW-1:0] RG_STAT   = 5'd1;
  localparam logic [REG_AW-1:0] RG_ID     = 5'd3;
  localparam logic [REG_AW-1:0] RG_CFG    = 5'd16;
  localparam logic [REG_AW-1:0] RG_SPEC   = 5'd17;
  localparam logic [REG_AW-1:0] RG_TUNE_A = 5'd24;
  localparam logic [REG_AW-1:0] RG_TUNE_B = 5'd25;
  localparam logic [REG_AW-1:0] RG_VEND   = 5'd31;

  localparam logic [DATA_W-1:0] LINK_MASK = 16'h0024;
  localparam logic [DATA_W-1:0] DUP_MASK  = 16'hA000;
  localparam logic [DATA_W-1:0] ID_MASK   = 16'hFFF0;
  localparam logic [DATA_W-1:0] ID_MATCH  = 16'hB900;
  localparam logic [DATA_W-1:0] ID_REV1   = 16'hB901;
  localparam logic [DATA_W-1:0] VEND_V1   = 16'h4404;

  localparam int MB_SF   = 21;
  localparam int MB_FDX  = 9;
  localparam int MB_ALT  = 18;
  localparam logic [MODE_W-1:0] MODE_BASE = 32'h0020_0000;

  typedef enum logic [3:0] {
    S_IDLE, S_FORCE10, S_POLL, S_SPEC, S_EMIT, S_ID,
    S_VEND, S_CFG, S_SRC, S_TUNE, S_FIN, S_HALT
  } seq_state_t;
endpackage

// File: rtl/phy_mode_timer.sv
module phy_mode_timer #(
  parameter int TIMEOUT_CYC = 400_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q >= LIMIT);
  assign cnt_en  = run && !expired;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/phy_mode_access.sv
module phy_mode_access
  import phy_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              cmd_wr,
  input  logic [REG_AW-1:0] cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              resp_done,
  output logic              req_valid,
  output logic              req_write,
  output logic [REG_AW-1:0] req_reg,
  output logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              ack
);
  logic busy_d;

  assign ack = busy && resp_done;

  always_comb begin
    busy_d = busy;
    if (go)       busy_d = 1'b1;
    else if (ack) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      req_valid <= 1'b0;
    end else begin
      busy      <= busy_d;
      req_valid <= go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_write <= 1'b0;
      req_reg   <= '0;
      req_wdata <= '0;
    end else if (go) begin
      req_write <= cmd_wr;
      req_reg   <= cmd_reg;
      req_wdata <= cmd_wdata;
    end
  end
endmodule

// File: rtl/phy_mode_patch.sv
module phy_mode_patch
  import phy_mode_pkg::*;
(
  input  logic              first_kind,
  input  logic [DATA_W-1:0] id_val,
  input  logic [DATA_W-1:0] src_val,
  output logic [REG_AW-1:0] src_reg,
  output logic [DATA_W-1:0] cfg_val,
  output logic [DATA_W-1:0] tune_val
);
  always_comb begin
    if (first_kind) begin
      src_reg  = RG_TUNE_A;
      cfg_val  = (id_val == ID_REV1) ? 16'h0005 : 16'h1005;
      tune_val = {8'hF0, src_val[7:0] + 8'd3};
    end else begin
      src_reg  = RG_TUNE_B;
      cfg_val  = 16'h0005;
      tune_val = {src_val[15:8], 8'h02};
    end
  end
endmodule

// File: rtl/phy_mode_seq.sv
module phy_mode_seq
  import phy_mode_pkg::*;
#(
  parameter int TIMEOUT_CYC = 400_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_10m,
  output logic              mreq_valid,
  output logic              mreq_write,
  output logic [REG_AW-1:0] mreq_reg,
  output logic [DATA_W-1:0] mreq_wdata,
  input  logic              mresp_done,
  input  logic [DATA_W-1:0] mresp_rdata,
  output logic [MODE_W-1:0] mode_word,
  output logic              mode_valid,
  output logic              seq_done
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  seq_state_t        state_q, state_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [DATA_W-1:0] id_q, id_d;
  logic [DATA_W-1:0] src_q, src_d;
  logic              kind_q, kind_d;
  logic              mode_en, id_en, src_en, kind_en;

  logic              is_acc, go, busy, ack, expired;
  logic              acc_wr;
  logic [REG_AW-1:0] acc_reg;
  logic [DATA_W-1:0] acc_wdata;
  logic [REG_AW-1:0] patch_reg;
  logic [DATA_W-1:0] patch_cfg, patch_tune;

  phy_mode_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_ni),
    .run     (state_q == S_POLL),
    .expired (expired)
  );

  phy_mode_patch u_patch (
    .first_kind (kind_q),
    .id_val     (id_q),
    .src_val    (src_q),
    .src_reg    (patch_reg),
    .cfg_val    (patch_cfg),
    .tune_val   (patch_tune)
  );

  phy_mode_access u_acc (
    .clk       (clk),
    .rst_n     (rst_ni),
    .go        (go),
    .cmd_wr    (acc_wr),
    .cmd_reg   (acc_reg),
    .cmd_wdata (acc_wdata),
    .resp_done (mresp_done),
    .req_valid (mreq_valid),
    .req_write (mreq_write),
    .req_reg   (mreq_reg),
    .req_wdata (mreq_wdata),
    .busy      (busy),
    .ack       (ack)
  );

  // access command for each step
  always_comb begin
    is_acc    = 1'b1;
    acc_wr    = 1'b0;
    acc_reg   = RG_STAT;
    acc_wdata = '0;
    unique case (state_q)
      S_FORCE10: begin acc_wr = 1'b1; acc_reg = RG_CTRL; end
      S_POLL:    acc_reg = RG_STAT;
      S_SPEC:    acc_reg = RG_SPEC;
      S_ID:      acc_reg = RG_ID;
      S_VEND:    acc_reg = RG_VEND;
      S_CFG:     begin acc_wr = 1'b1; acc_reg = RG_CFG; acc_wdata = patch_cfg; end
      S_SRC:     acc_reg = patch_reg;
      S_TUNE:    begin acc_wr = 1'b1; acc_reg = RG_TUNE_B; acc_wdata = patch_tune; end
      default:   is_acc = 1'b0;
    endcase
  end

  assign go = is_acc && !busy;

  // next state
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    id_d    = id_q;
    src_d   = src_q;
    kind_d  = kind_q;
    unique case (state_q)
      S_IDLE:    state_d = strap_10m ? S_FORCE10 : S_POLL;
      S_FORCE10: if (ack) state_d = S_EMIT;
      S_POLL: if (ack) begin
        if ((mresp_rdata & LINK_MASK) == LINK_MASK) state_d = S_SPEC;
        else if (expired) begin
          mode_d[MB_ALT] = 1'b1;
          state_d        = S_EMIT;
        end
      end
      S_SPEC: if (ack) begin
        if ((mresp_rdata & DUP_MASK) != '0) mode_d[MB_FDX] = 1'b1;
        state_d = S_EMIT;
      end
      S_EMIT:    state_d = mode_q[MB_ALT] ? S_ID : S_FIN;
      S_ID: if (ack) begin
        id_d    = mresp_rdata;
        state_d = ((mresp_rdata & ID_MASK) == ID_MATCH) ? S_VEND : S_FIN;
      end
      S_VEND: if (ack) begin
        kind_d  = (mresp_rdata == VEND_V1);
        state_d = S_CFG;
      end
      S_CFG:     if (ack) state_d = S_SRC;
      S_SRC: if (ack) begin
        src_d   = mresp_rdata;
        state_d = S_TUNE;
      end
      S_TUNE:    if (ack) state_d = S_FIN;
      S_FIN:     state_d = S_HALT;
      default:   state_d = S_HALT;
    endcase
  end

  assign mode_en = (state_q == S_POLL) || (state_q == S_SPEC);
  assign id_en   = (state_q == S_ID);
  assign src_en  = (state_q == S_SRC);
  assign kind_en = (state_q == S_VEND);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= MODE_BASE;
    else if (mode_en) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q   <= '0;
      src_q  <= '0;
      kind_q <= 1'b0;
    end else begin
      if (id_en)   id_q   <= id_d;
      if (src_en)  src_q  <= src_d;
      if (kind_en) kind_q <= kind_d;
    end
  end

  assign mode_word  = mode_q;
  assign mode_valid = (state_q == S_EMIT);
  assign seq_done   = (state_q == S_FIN);
endmodule

// File: rtl/phy_mode_seq_chk.sv
module phy_mode_seq_chk
  import phy_mode_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              strap_10m,
  input logic              mreq_valid,
  input logic              mreq_write,
  input logic [REG_AW-1:0] mreq_reg,
  input logic              mresp_done,
  input logic [MODE_W-1:0] mode_word,
  input logic              mode_valid,
  input logic              seq_done
);
  logic out_q, seen_mode_q, seen_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q       <= 1'b0;
      seen_mode_q <= 1'b0;
      seen_done_q <= 1'b0;
    end else begin
      if (mresp_done)      out_q <= 1'b0;
      else if (mreq_valid) out_q <= 1'b1;
      if (mode_valid) seen_mode_q <= 1'b1;
      if (seq_done)   seen_done_q <= 1'b1;
    end
  end

  // R2
  sf_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> mode_word[MB_SF]);

  // R3
  strap_only_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_10m && mreq_valid) |-> (mreq_write && mreq_reg == RG_CTRL));

  // R4
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> !out_q);

  // R4
  single_cycle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |=> !mreq_valid);

  // R7
  mode_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> !seen_mode_q);

  // R7
  no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_write && !strap_10m) |-> seen_mode_q);

  // R11
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !seen_done_q);

  // R11
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_done_q |-> !mreq_valid);

  // R11
  done_after_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (seen_mode_q && !mode_valid && !out_q));
endmodule

bind phy_mode_seq phy_mode_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strap_10m  (strap_10m),
  .mreq_valid (mreq_valid),
  .mreq_write (mreq_write),
  .mreq_reg   (mreq_reg),
  .mresp_done (mresp_done),
  .mode_word  (mode_word),
  .mode_valid (mode_valid),
  .seq_done   (seq_done)
);

// File: tb/phy_mode_seq_tb.sv
module phy_mode_seq_tb;
  localparam int T_OUT = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_10m = 1'b0;
  logic        mreq_valid, mreq_write;
  logic [4:0]  mreq_reg;
  logic [15:0] mreq_wdata;
  logic        mresp_done = 1'b0;
  logic [15:0] mresp_rdata = '0;
  logic [31:0] mode_word;
  logic        mode_valid, seq_done;

  always #2.5 clk = ~clk;

  phy_mode_seq #(.TIMEOUT_CYC(T_OUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_10m(strap_10m),
    .mreq_valid(mreq_valid), .mreq_write(mreq_write), .mreq_reg(mreq_reg),
    .mreq_wdata(mreq_wdata), .mresp_done(mresp_done), .mresp_rdata(mresp_rdata),
    .mode_word(mode_word), .mode_valid(mode_valid), .seq_done(seq_done)
  );

  int checks = 0, errors = 0;
  int cyc = 0;

  // transceiver model state
  logic [15:0] regs [32];
  int  link_after;
  int  stat_reads, n_wr, wr_before_mode, req_after_done;
  int  mv_cnt, dn_cnt, first_req_cyc, mode_cyc;
  logic [31:0] got_mode;
  logic [4:0]  wr_reg [8];
  logic [15:0] wr_dat [8];
  logic        pend;
  int          lat;
  logic [4:0]  p_reg;
  logic        p_wr;
  logic [15:0] p_dat;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stat_val(input int idx, input int after);
    if (after >= 0 && idx >= after) return 16'h782D;
    case (idx % 3)
      0: return 16'h7809;
      1: return 16'h7828;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic answer();
    mresp_done = 1'b1;
    if (p_wr) begin
      if (n_wr < 8) begin wr_reg[n_wr] = p_reg; wr_dat[n_wr] = p_dat; end
      n_wr++;
      if (mv_cnt == 0) wr_before_mode++;
      regs[p_reg] = p_dat;
      mresp_rdata = 16'h0;
    end else if (p_reg == 5'd1) begin
      mresp_rdata = stat_val(stat_reads, link_after);
      stat_reads++;
    end else begin
      mresp_rdata = regs[p_reg];
    end
    pend = 1'b0;
  endtask

  always @(negedge clk) begin
    cyc++;
    mresp_done = 1'b0;
    if (rst_n) begin
      if (mode_valid) begin mv_cnt++; got_mode = mode_word; mode_cyc = cyc; end
      if (seq_done) dn_cnt++;
      if (pend) begin
        if (lat == 0) answer(); else lat--;
      end
      if (mreq_valid) begin
        if (dn_cnt != 0) req_after_done++;
        if (first_req_cyc < 0) first_req_cyc = cyc;
        pend = 1'b1; p_reg = mreq_reg; p_wr = mreq_write; p_dat = mreq_wdata;
        lat = int'($urandom % 3);
        if (lat == 0) answer();
      end
    end
  end

  task automatic run_case(input bit s10, input int after, input logic [15:0] r17,
                          input logic [15:0] r3, input logic [15:0] r31,
                          input logic [15:0] r24, input logic [15:0] r25);
    logic [31:0] e_mode;
    logic [4:0]  e_reg [4];
    logic [15:0] e_dat [4];
    int e_n, lim;
    bit fb;
    for (int i = 0; i < 32; i++) regs[i] = 16'($urandom);
    regs[17] = r17; regs[3] = r3; regs[31] = r31; regs[24] = r24; regs[25] = r25;
    link_after = after;
    stat_reads = 0; n_wr = 0; wr_before_mode = 0; req_after_done = 0;
    mv_cnt = 0; dn_cnt = 0; first_req_cyc = -1; mode_cyc = -1; got_mode = '0;
    pend = 1'b0; lat = 0;
    // expected outcome from the requirements
    e_mode = 32'h0020_0000; e_n = 0; fb = 1'b0;
    if (s10) begin
      e_reg[0] = 5'd0; e_dat[0] = 16'h0; e_n = 1;
    end else if (after >= 0) begin
      if ((r17 & 16'hA000) != 0) e_mode[9] = 1'b1;
    end else begin
      fb = 1'b1; e_mode[18] = 1'b1;
      if ((r3 & 16'hFFF0) == 16'hB900) begin
        e_n = 2; e_reg[0] = 5'd16; e_reg[1] = 5'd25;
        if (r31 == 16'h4404) begin
          e_dat[0] = (r3 == 16'hB901) ? 16'h0005 : 16'h1005;
          e_dat[1] = {8'hF0, r24[7:0] + 8'd3};
        end else begin
          e_dat[0] = 16'h0005;
          e_dat[1] = (r25 & 16'hFF00) + 16'd2;
        end
      end
    end
    strap_10m = s10;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(!mreq_valid && !mode_valid && !seq_done && mode_word == 32'h0020_0000,
        "R1 reset state", {mreq_valid, mode_valid, seq_done, mode_word[28:0]}, 32'h0020_0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mreq_valid && !mode_valid && !seq_done, "R1 quiet after release",
        {mreq_valid, mode_valid, seq_done}, 32'h0);
    lim = 0;
    while (dn_cnt == 0 && lim < 3000) begin @(negedge clk); lim++; end
    repeat (6) @(negedge clk);
    chk(mv_cnt == 1, "R7 single mode strobe", mv_cnt, 1);
    chk(got_mode == e_mode, s10 ? "R3 mode word" : (fb ? "R6 mode word" : "R5 mode word"),
        got_mode, e_mode);
    chk(got_mode[21], "R2 store-and-forward bit", got_mode, e_mode);
    chk(dn_cnt == 1 && req_after_done == 0, "R11 done once, quiet after",
        dn_cnt * 16 + req_after_done, 16);
    chk(n_wr == e_n, e_n == 0 && fb ? "R8 write count" : "R9 R10 write count", n_wr, e_n);
    for (int i = 0; i < e_n && i < n_wr; i++) begin
      chk(wr_reg[i] == e_reg[i], "R9 R10 write register", wr_reg[i], e_reg[i]);
      chk(wr_dat[i] == e_dat[i], "R9 R10 write data", wr_dat[i], e_dat[i]);
    end
    if (s10) chk(stat_reads == 0, "R3 no status polling", stat_reads, 0);
    else begin
      chk(wr_before_mode == 0, "R7 no write before mode", wr_before_mode, 0);
      if (!fb) chk(stat_reads == after + 1, "R4 polls until link", stat_reads, after + 1);
      else chk(mode_cyc - first_req_cyc >= T_OUT, "R6 timeout honoured",
               mode_cyc - first_req_cyc, T_OUT);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    // directed corners
    run_case(1'b1, 0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);           // R3
    run_case(1'b0, 3, 16'h8000, 16'h0, 16'h0, 16'h0, 16'h0);         // R5 bit 15
    run_case(1'b0, 0, 16'h2000, 16'h0, 16'h0, 16'h0, 16'h0);         // R5 bit 13
    run_case(1'b0, 2, 16'h5FFF, 16'h0, 16'h0, 16'h0, 16'h0);         // R5 neither
    run_case(1'b0, -1, 16'h0, 16'h1234, 16'h4404, 16'h0, 16'h0);     // R8
    run_case(1'b0, -1, 16'h0, 16'hB901, 16'h4404, 16'h00FE, 16'h0);  // R9 wrap
    run_case(1'b0, -1, 16'h0, 16'hB905, 16'h4404, 16'h0010, 16'h0);  // R9 other rev
    run_case(1'b0, -1, 16'h0, 16'hB90A, 16'h1111, 16'h0, 16'hABCD);  // R10
    // random mix
    for (int k = 0; k < 10; k++) begin
      int a;
      logic [15:0] id;
      a  = ($urandom % 3 == 0) ? -1 : int'($urandom % 5);
      id = ($urandom % 4 == 0) ? 16'($urandom) : {12'hB90, 4'($urandom)};
      run_case(($urandom % 6) == 0, a, 16'($urandom), id,
               ($urandom % 2) ? 16'h4404 : 16'($urandom), 16'($urandom), 16'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule